// File: doc/BRIEF.md
# Flash Block Write-Protection State Machine

This block guards the erase and program rights of a set of flash array blocks. Each block holds a three-bit protection code. Bit 2 mirrors the hardware write-protect pin, bit 1 is a sticky lock-down flag, and bit 0 is the lock flag. Decoded lock, unlock and lock-down commands are addressed to one block at a time and change only that block's code. The shared write-protect pin changes every block's code at once. A block that has been locked down can be made writable again only while the pin is high. No command can release it.

The erase/program sequencer asks whether a block may be altered by presenting a request with a block index. A request to a block that refuses alteration, or to an index that names no block, produces a one-cycle error pulse. A request never changes any protection code. The per-block codes and allowed flags are outputs, one field per block.

Top module: `blockLockArray`

## Requirements
- R1: After reset every block holds code 3'b001 (lock set, lock-down clear, pin bit clear), every allowed flag is low and the error output is low.
- R2: On every clock edge each block's bit 2 takes the write-protect pin level sampled at that edge, so a high pin moves 000, 001 and 011 to 100, 101 and 111.
- R3: With the pin low at an edge, a block whose lock-down bit is set goes to 011, and any other block clears bit 2 (100 to 000, 101 to 001).
- R4: A lock command (cmdOp = 2'b01) sets bit 0 of the addressed block and leaves its other bits unchanged.
- R5: An unlock command (cmdOp = 2'b10) clears bit 0 of the addressed block, except in code 011 where nothing changes.
- R6: A lock-down command (cmdOp = 2'b11) sets bits 1 and 0 of the addressed block, so 000 and 001 go to 011 and 100, 101 and 110 go to 111.
- R7: Once set, a block's lock-down bit stays set until reset, and code 010 never appears.
- R8: cmdOp = 2'b00 changes nothing. A command changes no block other than the one at cmdBlock, and a cmdBlock at or above NUM_BLOCKS changes no block.
- R9: A block's allowed flag is high exactly when its code is 000, 100 or 110.
- R10: An erase/program request sampled at an edge raises reqError for the following cycle if the addressed block's allowed flag was low before that edge, or if the index is out of range. A request to an allowed block gives no error. A request never changes a code.
- R11: When a command and a pin change meet at the same edge, the pin update is applied first and the command is applied to its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpPin | input | 1 | Write-protect pin level, already synchronised |
| cmdOp | input | 2 | Decoded command: 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmdBlock | input | IDX_W | Block index the command addresses |
| eraseReq | input | 1 | Erase/program permission request |
| reqBlock | input | IDX_W | Block index of the request |
| stateCodes | output | 3*NUM_BLOCKS | Protection code of block i in bits [3i+2:3i] |
| allowed | output | NUM_BLOCKS | Erase/program-allowed flag per block |
| reqError | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions assume that wpPin is synchronous to clk and stable around the edge, and that cmdOp and the two indices are never X while reset is deasserted. They also assume that at most one command is decoded per cycle, which the single cmdOp field guarantees. The bench holds the pin low through reset, drives every input at the falling edge, and draws indices over the full IDX_W range, so out-of-range blocks are covered as legal stimulus. Pin toggles are drawn at a fixed rate so that same-edge pin and command collisions occur often.

// File: rtl/blkLockPkg.sv
package blkLockPkg;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_LOCK   = 2'b01,
    CMD_UNLOCK = 2'b10,
    CMD_DOWN   = 2'b11
  } lockCmd_e;

  // per-block strobes from control to datapath
  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setDown;
  } lockStrobe_t;

  localparam logic [2:0] RESET_CODE = 3'b001;

  // pin stage: code after the pin level is taken in
  function automatic logic [2:0] pinStage(input logic [2:0] cur, input logic pin);
    logic [2:0] res;
    if (pin)          res = {1'b1, cur[1:0]};
    else if (cur[1])  res = 3'b011;
    else              res = {1'b0, cur[1:0]};
    return res;
  endfunction

  // command stage, applied after the pin stage
  function automatic logic [2:0] cmdStage(input logic [2:0] cur, input lockStrobe_t s);
    logic [2:0] res;
    res = cur;
    if (s.setDown)      res[1:0] = 2'b11;
    else if (s.setLock) res[0] = 1'b1;
    else if (s.clrLock) begin
      if (cur != 3'b011) res[0] = 1'b0;
    end
    return res;
  endfunction

endpackage

// File: rtl/lockCtrl.sv
module lockCtrl
  import blkLockPkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [1:0]                        cmdOp,
  input  logic [IDX_W-1:0]                  cmdBlock,
  input  logic                              eraseReq,
  input  logic [IDX_W-1:0]                  reqBlock,
  input  logic [NUM_BLOCKS-1:0]             allowedVec,
  output lockStrobe_t [NUM_BLOCKS-1:0]      strobes,
  output logic                              reqError
);

  localparam logic [IDX_W:0] BLOCK_LIMIT = (IDX_W+1)'(NUM_BLOCKS);

  lockCmd_e opCode;
  assign opCode = lockCmd_e'(cmdOp);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_dec
    logic hit;
    assign hit = (cmdBlock == IDX_W'(i));
    always_comb begin
      strobes[i] = '0;
      if (hit) begin
        unique case (opCode)
          CMD_LOCK:   strobes[i].setLock = 1'b1;
          CMD_UNLOCK: strobes[i].clrLock = 1'b1;
          CMD_DOWN:   strobes[i].setDown = 1'b1;
          default:    strobes[i] = '0;
        endcase
      end
    end
  end

  logic reqInRange;
  logic refuseNow;
  assign reqInRange = ({1'b0, reqBlock} < BLOCK_LIMIT);

  always_comb begin
    refuseNow = 1'b0;
    if (eraseReq) begin
      if (!reqInRange) refuseNow = 1'b1;
      else             refuseNow = !allowedVec[reqBlock];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) reqError <= 1'b0;
    else       reqError <= refuseNow;
  end

endmodule

// File: rtl/lockStateBank.sv
module lockStateBank
  import blkLockPkg::*;
#(
  parameter int NUM_BLOCKS = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wpPin,
  input  lockStrobe_t [NUM_BLOCKS-1:0]  strobes,
  output logic [3*NUM_BLOCKS-1:0]       codes,
  output logic [NUM_BLOCKS-1:0]         allowedVec
);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    logic [2:0] code;
    logic [2:0] afterPin;

    assign afterPin = pinStage(code, wpPin);

    always_ff @(posedge clk) begin
      if (!rstN) code <= RESET_CODE;
      else       code <= cmdStage(afterPin, strobes[i]);
    end

    assign codes[3*i +: 3] = code;
    assign allowedVec[i]   = (code == 3'b000) || (code == 3'b100) || (code == 3'b110);
  end

endmodule

// File: rtl/blockLockArray.sv
module blockLockArray
  import blkLockPkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wpPin,
  input  logic [1:0]                cmdOp,
  input  logic [IDX_W-1:0]          cmdBlock,
  input  logic                      eraseReq,
  input  logic [IDX_W-1:0]          reqBlock,
  output logic [3*NUM_BLOCKS-1:0]   stateCodes,
  output logic [NUM_BLOCKS-1:0]     allowed,
  output logic                      reqError
);

  lockStrobe_t [NUM_BLOCKS-1:0] strobes;

  lockCtrl #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdOp      (cmdOp),
    .cmdBlock   (cmdBlock),
    .eraseReq   (eraseReq),
    .reqBlock   (reqBlock),
    .allowedVec (allowed),
    .strobes    (strobes),
    .reqError   (reqError)
  );

  lockStateBank #(.NUM_BLOCKS(NUM_BLOCKS)) u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .wpPin      (wpPin),
    .strobes    (strobes),
    .codes      (stateCodes),
    .allowedVec (allowed)
  );

endmodule

// File: rtl/blockLockChecker.sv
module blockLockChecker #(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wpPin,
  input logic [1:0]               cmdOp,
  input logic [IDX_W-1:0]         cmdBlock,
  input logic                     eraseReq,
  input logic [3*NUM_BLOCKS-1:0]  stateCodes,
  input logic [NUM_BLOCKS-1:0]    allowed,
  input logic                     reqError
);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_chk
    // R7: code 010 is never held
    p_no_bad_code_r7: assert property (@(posedge clk) disable iff (!rstN)
      stateCodes[3*i +: 3] != 3'b010);

    // R7: lock-down bit is sticky
    p_down_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      stateCodes[3*i+1] |=> stateCodes[3*i+1]);

    // R2: bit 2 follows the pin sampled at the edge
    p_pin_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (stateCodes[3*i+2] == $past(wpPin)));

    // R9: allowed only in unlocked codes
    p_allowed_r9: assert property (@(posedge clk) disable iff (!rstN)
      allowed[i] |-> (stateCodes[3*i] == 1'b0));

    // R4: lock command leaves the block locked
    p_lock_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
      (cmdOp == 2'b01 && cmdBlock == IDX_W'(i)) |=> stateCodes[3*i]);

    // R6: lock-down command sets both low bits
    p_down_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
      (cmdOp == 2'b11 && cmdBlock == IDX_W'(i)) |=> (stateCodes[3*i +: 2] == 2'b11));
  end

  // R10: an error pulse needs a request one edge earlier
  p_err_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> $past(eraseReq));

endmodule

bind blockLockArray blockLockChecker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wpPin      (wpPin),
  .cmdOp      (cmdOp),
  .cmdBlock   (cmdBlock),
  .eraseReq   (eraseReq),
  .stateCodes (stateCodes),
  .allowed    (allowed),
  .reqError   (reqError)
);

// File: tb/tb_blockLockArray.sv
`timescale 1ns/1ps
module tb_blockLockArray;

  localparam int NB = 6;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wpPin = 1'b0;
  logic [1:0]      cmdOp = 2'b00;
  logic [IW-1:0]   cmdBlock = '0;
  logic            eraseReq = 1'b0;
  logic [IW-1:0]   reqBlock = '0;
  logic [3*NB-1:0] stateCodes;
  logic [NB-1:0]   allowed;
  logic            reqError;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [2:0] model [NB];
  logic       expErr;

  always #4 clk = ~clk;

  blockLockArray #(.NUM_BLOCKS(NB)) dut (
    .clk(clk), .rstN(rstN), .wpPin(wpPin), .cmdOp(cmdOp), .cmdBlock(cmdBlock),
    .eraseReq(eraseReq), .reqBlock(reqBlock), .stateCodes(stateCodes),
    .allowed(allowed), .reqError(reqError)
  );

  // expected code from the requirement tables
  function automatic logic [2:0] expNext(input logic [2:0] c, input logic wp, input logic [1:0] op);
    logic [2:0] p;
    case ({wp, c})
      4'b1_000: p = 3'b100;
      4'b1_001: p = 3'b101;
      4'b1_011: p = 3'b111;
      4'b0_100: p = 3'b000;
      4'b0_101: p = 3'b001;
      4'b0_110: p = 3'b011;
      4'b0_111: p = 3'b011;
      default:  p = c;
    endcase
    case (op)
      2'b01: p = p | 3'b001;
      2'b10: if (p != 3'b011) p = p & 3'b110;
      2'b11: p = p | 3'b011;
      default: ;
    endcase
    return p;
  endfunction

  function automatic logic expAllowed(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b100) || (c == 3'b110);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [3*NB-1:0] ec;
    logic [NB-1:0]   ea;
    for (int i = 0; i < NB; i++) begin
      ec[3*i +: 3] = model[i];
      ea[i] = expAllowed(model[i]);
    end
    check(stateCodes == ec, tag, 32'(stateCodes), 32'(ec));
    check(allowed == ea, "R9", 32'(allowed), 32'(ea));
    check(reqError == expErr, "R10", 32'(reqError), 32'(expErr));
  endtask

  // one clock: drive at falling edge, update model, compare at next falling edge
  task automatic step(input logic wp, input logic [1:0] op, input logic [IW-1:0] blk,
                      input logic rq, input logic [IW-1:0] rblk, input string tag);
    wpPin = wp; cmdOp = op; cmdBlock = blk; eraseReq = rq; reqBlock = rblk;
    expErr = rq && ((int'(rblk) >= NB) || !expAllowed(model[rblk]));
    for (int i = 0; i < NB; i++)
      model[i] = expNext(model[i], wp, (int'(blk) == i) ? op : 2'b00);
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) model[i] = 3'b001;
    expErr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;

    step(1'b0, 2'b10, 3'd0, 1'b0, 3'd0, "R5");   // b0 -> 000
    step(1'b0, 2'b01, 3'd0, 1'b1, 3'd1, "R4");   // b0 -> 001, b1 refused
    step(1'b0, 2'b10, 3'd0, 1'b0, 3'd0, "R5");   // b0 -> 000
    step(1'b0, 2'b00, 3'd0, 1'b1, 3'd0, "R10");  // allowed, no error
    step(1'b1, 2'b00, 3'd0, 1'b0, 3'd0, "R2");   // pin high: 100 / 101
    step(1'b1, 2'b11, 3'd2, 1'b0, 3'd0, "R6");   // b2 101 -> 111
    step(1'b1, 2'b10, 3'd2, 1'b0, 3'd0, "R5");   // b2 -> 110
    step(1'b1, 2'b00, 3'd0, 1'b1, 3'd2, "R10");  // 110 allowed
    step(1'b0, 2'b00, 3'd0, 1'b0, 3'd0, "R3");   // b2 -> 011, others clear bit2
    step(1'b0, 2'b10, 3'd2, 1'b0, 3'd0, "R5");   // 011 unchanged
    step(1'b0, 2'b01, 3'd2, 1'b0, 3'd0, "R8");   // lock on 011 unchanged
    step(1'b0, 2'b10, 3'd7, 1'b0, 3'd0, "R8");   // out-of-range command
    step(1'b0, 2'b00, 3'd1, 1'b1, 3'd6, "R10");  // out-of-range request
    step(1'b1, 2'b10, 3'd2, 1'b0, 3'd0, "R11");  // pin high and unlock: 011 -> 110
    step(1'b0, 2'b00, 3'd0, 1'b0, 3'd0, "R7");   // back to 011, lock-down kept
    step(1'b0, 2'b11, 3'd3, 1'b0, 3'd0, "R6");   // b3 001 -> 011

    for (int n = 0; n < 600; n++) begin
      logic wp;
      wp = (($urandom % 5) == 0) ? ~wpPin : wpPin;
      step(wp, 2'($urandom), 3'($urandom), 1'($urandom), 3'($urandom), "R11");
    end

    // reset again clears lock-down
    rstN = 1'b0;
    for (int i = 0; i < NB; i++) model[i] = 3'b001;
    expErr = 1'b0;
    wpPin = 1'b0; cmdOp = 2'b00; eraseReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    step(1'b0, 2'b10, 3'd2, 1'b0, 3'd0, "R7");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule